// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting timer channel of the classic interval-timer kind. A count-enable tick paces it, and a gate input can enable it or retrigger it. A separate access block decodes the bus and control words and drives this channel directly. That block presents a mode number, a binary/BCD select and a load strobe with a new initial count. The channel returns its live count and its OUT line.

Six behaviours are supported. Modes 0 and 1 are one-shot and set OUT once. Modes 4 and 5 are strobes that pulse OUT for one tick. Mode 2 is a rate generator with a one-tick pulse per period. Mode 3 is a square wave. The one-shot and strobe modes keep counting past zero and wrap. The periodic modes reload their initial count. A loaded value of zero stands for the largest count. Every change of count or OUT that comes from counting happens on a clock edge where the tick input is high.

Top module: `ictr_channel`

## Requirements
- R1: While `rst_n` is low, and after its release until the first load, `count_o` is 0 and `out_o` is 1. Ticks before the first load change neither.
- R2: A load does not change `count_o` on its own edge. At that edge OUT takes its start level: 1 in mode 3 and 0 in every other mode. The loaded value appears on `count_o` at the first tick after the load. This tick is elapsed tick 0.
- R3: Mode 0 (`mode_i`=0). OUT stays 0 until elapsed tick N and then stays 1. The count decrements by one per tick and wraps from 0 to FFFF hex.
- R4: In modes 0 and 4 a low gate holds the count across ticks. A rising gate edge in these modes does not restart the count.
- R5: Mode 1 (`mode_i`=1). The gate level has no effect. A rising gate edge restarts the count: the initial value reappears at the next tick, and OUT is 0 until N ticks later, then 1.
- R6: Mode 2 (`mode_i`=2). The count runs N down to 1. The tick after 1 reloads N. OUT is 1 for exactly the one tick at each elapsed multiple of N, and 0 otherwise (N at least 2).
- R7: Mode 3 (`mode_i`=3). The count starts at N rounded down to even and falls by two per tick. OUT is 1 for ceil(N/2) ticks and 0 for floor(N/2) ticks in each period of N ticks (N at least 2).
- R8: Modes 4 and 5 (`mode_i`=4, 5). OUT is 1 for exactly one tick, at elapsed tick N. The count keeps decrementing and wrapping, and OUT does not pulse again on later passes through zero.
- R9: Mode 5. The gate level has no effect. A rising gate edge restarts the count from the initial value at the next tick, and the strobe repeats N ticks later.
- R10: A loaded value of 0 acts as 65536 in binary (10000 in BCD). The first decrement gives FFFF hex (9999 BCD), with no terminal event at that point.
- R11: With `bcd_i`=1 the count decrements as four decimal digits with borrow, so 0010 becomes 0009. The wrap goes from 0000 to 9999.
- R12: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R13: On a clock edge with `tick_i` low, `count_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one pulse per counting step |
| gate_i | input | 1 | Gate: level enable or rising-edge retrigger, depending on mode |
| mode_i | input | 3 | Counting mode 0..7 (6 and 7 alias 2 and 3) |
| bcd_i | input | 1 | 1 selects four-digit decimal counting |
| load_i | input | 1 | Strobe that writes a new initial count |
| load_val_i | input | 16 | Initial count to load (0 means maximum) |
| count_o | output | 16 | Current counter value |
| out_o | output | 1 | Channel output line |

## Verification
Most internal faults in this channel show at the ports on the very next tick. A wrong borrow, parity hold bit or reload choice appears at once as a wrong `count_o`. A wrong OUT phase in mode 3 takes up to half a period to show, when the toggle comes one tick early or late. A stale retrigger flag stays hidden until the next tick, where it shows as an unexpected return to the initial count. A missing "already strobed" flag in modes 4 and 5 stays hidden for a full wrap of the counter. The bench therefore compares count and OUT after every tick of short, hand-computed sequences.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

   typedef enum logic [2:0] {
      ONE_SHOT_SW = 3'd0,
      ONE_SHOT_HW = 3'd1,
      RATE        = 3'd2,
      SQUARE      = 3'd3,
      STROBE_SW   = 3'd4,
      STROBE_HW   = 3'd5
   } ictr_mode_e;

   // codes 6 and 7 fold onto the periodic modes
   function automatic ictr_mode_e fold_mode(input logic [2:0] m);
      if (m[2] && m[1])
         return ictr_mode_e'({1'b0, m[1:0]});
      return ictr_mode_e'(m);
   endfunction

   // OUT level right after a load or a restart
   function automatic logic start_level(input ictr_mode_e m);
      return (m == SQUARE);
   endfunction

endpackage

// File: rtl/ictr_dec1.sv
module ictr_dec1 #(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic [CNT_W-1:0] val_i,
   input  logic             bcd_i,
   output logic [CNT_W-1:0] res_o
);
   localparam int DIGITS = CNT_W / 4;

   logic [CNT_W-1:0] bin_res;
   assign bin_res = val_i - {{(CNT_W-1){1'b0}}, 1'b1};

   if (BCD_EN) begin : g_bcd
      logic [DIGITS-1:0] brw;
      logic [CNT_W-1:0]  dec_res;
      assign brw[0] = 1'b1;
      for (genvar g = 0; g < DIGITS; g++) begin : g_dig
         logic [3:0] dg;
         assign dg = val_i[4*g +: 4];
         assign dec_res[4*g +: 4] = !brw[g] ? dg :
                                    ((dg == 4'd0) ? 4'd9 : dg - 4'd1);
         if (g < DIGITS - 1) begin : g_nxt
            assign brw[g+1] = brw[g] & (dg == 4'd0);
         end
      end
      assign res_o = bcd_i ? dec_res : bin_res;
   end else begin : g_bin
      logic unused_bcd;
      assign unused_bcd = bcd_i;
      assign res_o      = bin_res;
   end
endmodule

// File: rtl/ictr_trigger.sv
module ictr_trigger
   import ictr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gate_i,
   input  ictr_mode_e mode_i,
   output logic       restart_o,
   output logic       run_ok_o
);
   logic gate_q;
   logic retrig;
   logic level_free;

   always_ff @(posedge clk) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= gate_i;
   end

   always_comb begin
      case (mode_i)
         ONE_SHOT_HW, STROBE_HW: begin retrig = 1'b1; level_free = 1'b1; end
         RATE, SQUARE:           begin retrig = 1'b1; level_free = 1'b0; end
         default:                begin retrig = 1'b0; level_free = 1'b0; end
      endcase
   end

   assign restart_o = gate_i & ~gate_q & retrig;
   assign run_ok_o  = gate_i | level_free;
endmodule

// File: rtl/ictr_channel.sv
module ictr_channel
   import ictr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             gate_i,
   input  logic [2:0]       mode_i,
   input  logic             bcd_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             out_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   if (CNT_W < 4) begin : g_bad_width
      $error("ictr_channel: CNT_W must be at least 4");
   end
   if (BCD_EN && (CNT_W % 4 != 0)) begin : g_bad_bcd
      $error("ictr_channel: decimal counting needs CNT_W a multiple of 4");
   end

   ictr_mode_e       mode_e;
   logic [CNT_W-1:0] init_q, cnt_q, dec1, dec2, init_even;
   logic             pend_q, armed_q, done_q, hold_q, out_q;
   logic             restart, run_ok;

   assign mode_e    = fold_mode(mode_i);
   assign init_even = {init_q[CNT_W-1:1], 1'b0};

   ictr_dec1 #(.CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_dec_a (
      .val_i(cnt_q), .bcd_i(bcd_i), .res_o(dec1));
   ictr_dec1 #(.CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_dec_b (
      .val_i(dec1),  .bcd_i(bcd_i), .res_o(dec2));

   ictr_trigger u_trig (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .mode_i(mode_e),
      .restart_o(restart), .run_ok_o(run_ok));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q  <= '0;
         cnt_q   <= '0;
         pend_q  <= 1'b0;
         armed_q <= 1'b0;
         done_q  <= 1'b0;
         hold_q  <= 1'b0;
         out_q   <= 1'b1;
      end else begin
         if (tick_i && !load_i) begin
            if (pend_q) begin
               cnt_q  <= (mode_e == SQUARE) ? init_even : init_q;
               hold_q <= (mode_e == SQUARE) & init_q[0];
               pend_q <= 1'b0;
               done_q <= 1'b0;
               out_q  <= start_level(mode_e);
            end else if (armed_q && run_ok) begin
               case (mode_e)
                  ONE_SHOT_SW, ONE_SHOT_HW: begin
                     cnt_q <= dec1;
                     if (cnt_q == ONE) out_q <= 1'b1;
                  end
                  STROBE_SW, STROBE_HW: begin
                     cnt_q <= dec1;
                     out_q <= (cnt_q == ONE) && !done_q;
                     if (cnt_q == ONE) done_q <= 1'b1;
                  end
                  RATE: begin
                     if (cnt_q == ONE) begin
                        cnt_q <= init_q;
                        out_q <= 1'b1;
                     end else begin
                        cnt_q <= dec1;
                        out_q <= 1'b0;
                     end
                  end
                  SQUARE: begin
                     if (hold_q) begin
                        hold_q <= 1'b0;
                     end else if (cnt_q == TWO) begin
                        out_q  <= ~out_q;
                        cnt_q  <= init_even;
                        hold_q <= ~out_q & init_q[0];
                     end else begin
                        cnt_q <= dec2;
                     end
                  end
                  default: ;
               endcase
            end
         end
         if (load_i) begin
            init_q  <= load_val_i;
            pend_q  <= 1'b1;
            armed_q <= 1'b1;
            done_q  <= 1'b0;
            out_q   <= start_level(mode_e);
         end else if (restart && armed_q) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign count_o = cnt_q;
   assign out_o   = out_q;
endmodule

// File: rtl/ictr_channel_chk.sv
module ictr_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             gate_i,
   input logic [2:0]       mode_i,
   input logic             load_i,
   input logic             pend,
   input logic [CNT_W-1:0] count_o,
   input logic             out_o
);
   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (out_o && count_o == '0));

   assert_load_defers_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> $stable(count_o));

   assert_m0_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd0 && out_o && !load_i) |=> out_o);

   assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == 3'd0 || mode_i == 3'd4) && !gate_i && tick_i && !load_i && !pend)
      |=> $stable(count_o));

   assert_rate_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd2 && out_o && tick_i && gate_i && !load_i && !pend
       && count_o != CNT_W'(1)) |=> !out_o);

   assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == 3'd4 || mode_i == 3'd5) && out_o && tick_i && !load_i) |=> !out_o);

   assert_idle_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(count_o));
endmodule

bind ictr_channel ictr_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i),
   .mode_i(mode_i), .load_i(load_i), .pend(pend_q),
   .count_o(count_o), .out_o(out_o));

// File: tb/ictr_channel_bench.sv
`timescale 1ns/1ps
module ictr_channel_bench;
   typedef struct {
      logic [15:0] c;
      logic        o;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, gate = 1'b1, bcd = 1'b0, load = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [15:0] load_val = '0;
   logic [15:0] count;
   logic        out;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;
   exp_t        exp_q[$];

   always #2.5 clk = ~clk;

   ictr_channel u_ictr_channel (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .gate_i(gate),
      .mode_i(mode), .bcd_i(bcd), .load_i(load), .load_val_i(load_val),
      .count_o(count), .out_o(out));

   task automatic cyc(input logic t, input logic ld, input logic [15:0] v);
      @(negedge clk);
      tick = t; load = ld; load_val = v;
      @(posedge clk);
      #1;
   endtask

   task automatic expect_state(input logic [15:0] c, input logic o, input string tag);
      exp_t it;
      it.c = c; it.o = o; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic tk(input logic [15:0] c, input logic o, input string tag);
      cyc(1'b1, 1'b0, 16'h0);
      expect_state(c, o, tag);
   endtask

   task automatic ld(input logic [15:0] v, input logic [15:0] c, input string tag);
      cyc(1'b0, 1'b1, v);
      expect_state(c, (mode == 3'd3 || mode == 3'd7), tag);
   endtask

   // monitor: compares queued expectations away from the clock edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (count !== it.c || out !== it.o) begin
               errors++;
               $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
                        it.tag, count, out, it.c, it.o);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state and idle before any load
      cyc(1'b1, 1'b0, 16'h0); expect_state(16'h0, 1'b1, "R1");
      cyc(1'b0, 1'b0, 16'h0);
      @(negedge clk); rst_n = 1'b1;
      tk(16'h0, 1'b1, "R1"); tk(16'h0, 1'b1, "R1");

      // mode 0 binary
      mode = 3'd0; gate = 1'b1;
      ld(16'd3, 16'h0, "R2");
      tk(16'd3, 1'b0, "R2"); tk(16'd2, 1'b0, "R3"); tk(16'd1, 1'b0, "R3");
      tk(16'd0, 1'b1, "R3"); tk(16'hFFFF, 1'b1, "R3");
      cyc(1'b0, 1'b0, 16'h0); expect_state(16'hFFFF, 1'b1, "R13");

      // gate level in mode 0
      ld(16'd5, 16'hFFFF, "R2");
      tk(16'd5, 1'b0, "R4");
      gate = 1'b0; tk(16'd5, 1'b0, "R4"); tk(16'd5, 1'b0, "R4");
      gate = 1'b1; tk(16'd4, 1'b0, "R4");

      // mode 1 retrigger
      mode = 3'd1;
      ld(16'd4, 16'd4, "R2");
      tk(16'd4, 1'b0, "R5"); tk(16'd3, 1'b0, "R5"); tk(16'd2, 1'b0, "R5");
      gate = 1'b0; tk(16'd1, 1'b0, "R5");
      gate = 1'b1; cyc(1'b0, 1'b0, 16'h0); expect_state(16'd1, 1'b0, "R5");
      tk(16'd4, 1'b0, "R5"); tk(16'd3, 1'b0, "R5"); tk(16'd2, 1'b0, "R5");
      tk(16'd1, 1'b0, "R5"); tk(16'd0, 1'b1, "R5");

      // mode 2 rate generator
      mode = 3'd2;
      ld(16'd3, 16'd0, "R2");
      tk(16'd3, 1'b0, "R6"); tk(16'd2, 1'b0, "R6"); tk(16'd1, 1'b0, "R6");
      tk(16'd3, 1'b1, "R6"); tk(16'd2, 1'b0, "R6"); tk(16'd1, 1'b0, "R6");
      tk(16'd3, 1'b1, "R6");

      // mode 3 square wave, odd count
      mode = 3'd3;
      ld(16'd5, 16'd3, "R2");
      tk(16'd4, 1'b1, "R7"); tk(16'd4, 1'b1, "R7"); tk(16'd2, 1'b1, "R7");
      tk(16'd4, 1'b0, "R7"); tk(16'd2, 1'b0, "R7");
      tk(16'd4, 1'b1, "R7"); tk(16'd4, 1'b1, "R7");

      // code 7 behaves as mode 3, even count
      mode = 3'd7;
      ld(16'd4, 16'd4, "R12");
      tk(16'd4, 1'b1, "R12"); tk(16'd2, 1'b1, "R12");
      tk(16'd4, 1'b0, "R12"); tk(16'd2, 1'b0, "R12"); tk(16'd4, 1'b1, "R12");

      // mode 4 strobe
      mode = 3'd4;
      ld(16'd2, 16'd4, "R2");
      tk(16'd2, 1'b0, "R8"); tk(16'd1, 1'b0, "R8"); tk(16'd0, 1'b1, "R8");
      tk(16'hFFFF, 1'b0, "R8"); tk(16'hFFFE, 1'b0, "R8");

      // mode 5 strobe with retrigger
      mode = 3'd5;
      ld(16'd2, 16'hFFFE, "R2");
      tk(16'd2, 1'b0, "R9"); tk(16'd1, 1'b0, "R9"); tk(16'd0, 1'b1, "R9");
      tk(16'hFFFF, 1'b0, "R9");
      gate = 1'b0; cyc(1'b0, 1'b0, 16'h0); expect_state(16'hFFFF, 1'b0, "R9");
      gate = 1'b1; cyc(1'b0, 1'b0, 16'h0); expect_state(16'hFFFF, 1'b0, "R9");
      tk(16'd2, 1'b0, "R9"); tk(16'd1, 1'b0, "R9"); tk(16'd0, 1'b1, "R9");
      tk(16'hFFFF, 1'b0, "R9");

      // zero means maximum, binary
      mode = 3'd0;
      ld(16'd0, 16'hFFFF, "R10");
      tk(16'd0, 1'b0, "R10"); tk(16'hFFFF, 1'b0, "R10"); tk(16'hFFFE, 1'b0, "R10");
      mode = 3'd2;
      ld(16'd0, 16'hFFFE, "R10");
      tk(16'd0, 1'b0, "R10"); tk(16'hFFFF, 1'b0, "R10");

      // decimal counting
      mode = 3'd0; bcd = 1'b1;
      ld(16'h0010, 16'hFFFF, "R11");
      tk(16'h0010, 1'b0, "R11"); tk(16'h0009, 1'b0, "R11"); tk(16'h0008, 1'b0, "R11");
      ld(16'h0000, 16'h0008, "R11");
      tk(16'h0000, 1'b0, "R11"); tk(16'h9999, 1'b0, "R11"); tk(16'h9998, 1'b0, "R11");
      bcd = 1'b0;

      // code 6 behaves as mode 2
      mode = 3'd6;
      ld(16'd2, 16'h9998, "R12");
      tk(16'd2, 1'b0, "R12"); tk(16'd1, 1'b0, "R12"); tk(16'd2, 1'b1, "R12");

      cyc(1'b0, 1'b0, 16'h0);
      cyc(1'b0, 1'b0, 16'h0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule